// File: doc/BRIEF.md
# Split-Divisor Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that sends and receives NRZ characters. Each character starts with a low start bit, carries its data least significant bit first, and ends with one high stop bit. A character holds 8 or 9 bits. Parity is optional, and when it is on, the parity bit replaces the most significant bit of the selected length. Software drives the block through five 8-bit registers on a simple read/write strobe bus. The block has one serial output, one serial input and one level interrupt.

Both directions share one clock prescaler, and each direction then has its own power-of-two divider, so the transmit and receive rates can differ. The receiver runs at sixteen ticks per bit. It takes a majority vote over the 8th, 9th and 10th ticks of each bit and rejects a start bit that does not hold low. The transmitter has a holding register ahead of its shift register. It can also send back-to-back break characters, followed by one high bit when the break ends.

Top module: `uart_split_baud`

## Requirements
- R1: After reset the status register (address 0) reads C0h, the serial output is high and the interrupt is low.
- R2: A transmitted character consists of a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts 16 transmit ticks.
- R3: The rate register (address 2) works as follows. Bits 7:6 select the prescaler: code 0 divides by 1, 1 by 3, 2 by 4 and 3 by 13. Bits 5:3 set the transmit divider and bits 2:0 set the receive divider, each dividing by 2 to the power of its code. One bit therefore lasts 16 × prescaler × divider clock cycles.
- R4: Setting bit 4 of control A (address 3) selects 9-bit characters. The 9th transmitted bit is taken from control A bit 6, and the 9th received bit is read back in control A bit 7.
- R5: Control A bit 2 enables parity and bit 1 selects odd parity (0 = even). The parity bit occupies the top bit of the selected length. A received parity mismatch sets status bit 0.
- R6: A write to the data register (address 1) clears status bit 7 (holding register empty) and bit 6 (transmission complete). Bit 7 sets again once the character moves into the shift register. Bit 6 sets when a character ends and the holding register is empty. Control B (address 4) bit 3 enables the transmitter.
- R7: The receiver samples every bit at ticks 8, 9 and 10 of 16 and keeps the majority. Any disagreement within a character sets status bit 2. A start bit that reads high by majority is dropped without a character being reported.
- R8: A received character sets status bit 5 and is read from address 1. That read clears status bits 5, 3, 2, 1 and 0. Control B bit 2 enables the receiver.
- R9: If a character completes while status bit 5 is still set, status bit 3 sets, the held character is kept and the new one is lost.
- R10: A stop bit sampled low sets status bit 1, and the character is still delivered.
- R11: While control B bit 0 is set, the output sends all-zero break characters continuously. After the bit is cleared, the output stays high for at least one full bit before the next start bit.
- R12: The interrupt output is the OR of three terms: status bit 7 when control B bit 7 is set, status bit 6 when control B bit 6 is set, and status bit 5 or 3 when control B bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect on the data address) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a noisy bit that the receiver still decodes correctly. It requires a pulse that disturbs exactly one of the three voting ticks, so it depends on the receiver's tick phase. With the fastest rate setting, that phase is fixed by the two-stage input synchronizer. The bench therefore inverts one data bit for a single clock at offset 8 of its 16 cycles, expects the correct data, and expects the noise flag to be set. False starts, overruns and low stop bits are produced by shaping the serial input directly. Transmit checks sample at the middle of each bit, measured from the observed falling edge.

// File: rtl/uart_sb_pkg.sv
package uart_sb_pkg;
  localparam int OVS   = 16;
  localparam int SUBW  = $clog2(OVS);
  localparam int DIVCW = 3;
  localparam int DCNTW = 1 << DIVCW;
  localparam int WMAX  = 9;
  localparam int FRW   = WMAX + 2;

  localparam logic [2:0] ADR_STAT = 3'd0;
  localparam logic [2:0] ADR_DATA = 3'd1;
  localparam logic [2:0] ADR_RATE = 3'd2;
  localparam logic [2:0] ADR_CTLA = 3'd3;
  localparam logic [2:0] ADR_CTLB = 3'd4;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_BRK, TX_MARK} tx_st_e;

  function automatic logic [3:0] presc_factor(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd13;
    endcase
  endfunction

  function automatic logic [DCNTW-1:0] div_factor(input logic [DIVCW-1:0] code);
    return DCNTW'(1) << code;
  endfunction

  // Character with parity inserted in its top bit when enabled.
  function automatic logic [WMAX-1:0] tx_word(input logic [WMAX-1:0] w, input logic nine,
                                              input logic pen, input logic odd);
    logic [WMAX-1:0] r;
    r = w;
    if (!nine) r[8] = 1'b0;
    if (pen) begin
      if (nine) r[8] = (^w[7:0]) ^ odd;
      else      r[7] = (^w[6:0]) ^ odd;
    end
    return r;
  endfunction

  function automatic logic parity_bad(input logic [WMAX-1:0] w, input logic nine, input logic odd);
    return nine ? ((^w[8:0]) != odd) : ((^w[7:0]) != odd);
  endfunction
endpackage

// File: rtl/uart_sb_baud.sv
module uart_sb_baud
  import uart_sb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rate,
  output logic       tx_tick,
  output logic       rx_tick
);
  logic [3:0] pcnt;
  logic       pre_tick;
  logic [1:0] ticks;

  assign pre_tick = (pcnt >= presc_factor(rate[7:6]) - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (pre_tick) pcnt <= '0;
    else               pcnt <= pcnt + 4'd1;
  end

  // Prescaler period above one never yields two adjacent pulses (R3).
  p_pre_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && rate[7:6] != 2'd0 && $stable(rate)) |=> !pre_tick);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_div
      logic [DCNTW-1:0] cnt;
      logic [DIVCW-1:0] code;
      assign code     = (g == 0) ? rate[5:3] : rate[2:0];
      assign ticks[g] = pre_tick && (cnt >= div_factor(code) - DCNTW'(1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (ticks[g]) cnt <= '0;
        else if (pre_tick) cnt <= cnt + DCNTW'(1);
      end
    end
  endgenerate

  assign tx_tick = ticks[0];
  assign rx_tick = ticks[1];
endmodule

// File: rtl/uart_sb_tx.sv
module uart_sb_tx
  import uart_sb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            tx_en,
  input  logic            brk_req,
  input  logic            pending,
  input  logic            nine,
  input  logic [WMAX-1:0] word,
  output logic            load,
  output logic            frame_end,
  output logic            tx_o
);
  tx_st_e          st;
  logic [FRW-1:0]  sh;
  logic [3:0]      bitno;
  logic [SUBW-1:0] sub;
  logic [3:0]      last_bit;

  assign last_bit = nine ? 4'd10 : 4'd9;
  assign load     = (st == TX_IDLE) && tick && !brk_req && tx_en && pending;
  assign tx_o     = (st == TX_SEND) ? sh[0] : (st != TX_BRK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; sh <= '1; bitno <= '0; sub <= '0; frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (st == TX_IDLE) begin
        if (tick) begin
          sub <= '0; bitno <= '0;
          if (brk_req) st <= TX_BRK;
          else if (load) begin
            st <= TX_SEND;
            sh <= nine ? {1'b1, word, 1'b0} : {2'b11, word[7:0], 1'b0};
          end
        end
      end else if (tick) begin
        sub <= sub + SUBW'(1);
        if (sub == SUBW'(OVS - 1)) begin
          bitno <= bitno + 4'd1;
          sh    <= {1'b1, sh[FRW-1:1]};
          if (st == TX_MARK) st <= TX_IDLE;
          else if (bitno == last_bit) begin
            if (st == TX_SEND) begin
              st <= TX_IDLE; frame_end <= 1'b1;
            end else begin
              bitno <= '0;
              if (!brk_req) st <= TX_MARK;
            end
          end
        end
      end
    end
  end

  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_SEND && bitno == last_bit) |-> tx_o);
  p_break_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_BRK && brk_req) |=> !tx_o);
endmodule

// File: rtl/uart_sb_rx.sv
module uart_sb_rx
  import uart_sb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rx_en,
  input  logic            rx_s,
  input  logic            nine,
  output logic            done,
  output logic            noise,
  output logic            ferr,
  output logic [WMAX-1:0] word
);
  logic            busy, sa, sb, nacc, maj, disagree;
  logic [3:0]      bitno, stop_idx, idx;
  logic [SUBW-1:0] sub, sub_n;

  assign stop_idx = nine ? 4'd10 : 4'd9;
  assign sub_n    = sub + SUBW'(1);
  assign idx      = bitno - 4'd1;
  assign maj      = (sa & sb) | (sa & rx_s) | (sb & rx_s);
  assign disagree = (sa != sb) || (sb != rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bitno <= '0; sub <= '0; sa <= 1'b1; sb <= 1'b1; nacc <= 1'b0;
      done <= 1'b0; noise <= 1'b0; ferr <= 1'b0; word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (tick && rx_en && !rx_s) begin
          busy <= 1'b1; bitno <= '0; sub <= '0; nacc <= 1'b0; word <= '0;
        end
      end else if (tick) begin
        sub <= sub_n;
        if (sub_n == SUBW'(7)) sa <= rx_s;
        if (sub_n == SUBW'(8)) sb <= rx_s;
        if (sub_n == SUBW'(9)) begin
          nacc <= nacc | disagree;
          if (bitno == 4'd0) begin
            if (maj) busy <= 1'b0;
          end else if (bitno == stop_idx) begin
            busy <= 1'b0; done <= 1'b1; ferr <= !maj; noise <= nacc | disagree;
          end else begin
            word[idx] <= maj;
          end
        end
        if (sub == SUBW'(OVS - 1)) bitno <= bitno + 4'd1;
      end
    end
  end

  p_false_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && bitno == 4'd0 && sub_n == SUBW'(9) && maj) |=> (!busy && !done));
endmodule

// File: rtl/uart_split_baud.sv
module uart_split_baud
  import uart_sb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       irq_o
);
  logic [7:0] rate_q, ctlb_q, hold_q, rx_byte;
  logic       tx9_q, nine_q, pen_q, odd_q, rx9_q;
  logic       st_txe, st_txc, st_rxf, st_ovr, st_nf, st_fe, st_pe;
  logic       rx_meta, rx_s;
  logic       tx_tick, rx_tick, tx_load, tx_end, rx_done, rx_noise, rx_ferr;
  logic [WMAX-1:0] rx_word;
  logic       wr_data, rd_clr;

  assign wr_data = reg_wr && reg_addr == ADR_DATA;
  assign rd_clr  = reg_rd && reg_addr == ADR_DATA;

  uart_sb_baud u_baud (.clk(clk), .rst_n(rst_n), .rate(rate_q), .tx_tick(tx_tick), .rx_tick(rx_tick));

  uart_sb_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .tx_en(ctlb_q[3]), .brk_req(ctlb_q[0]),
    .pending(!st_txe), .nine(nine_q), .word(tx_word({tx9_q, hold_q}, nine_q, pen_q, odd_q)),
    .load(tx_load), .frame_end(tx_end), .tx_o(tx_o));

  uart_sb_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rx_en(ctlb_q[2]), .rx_s(rx_s), .nine(nine_q),
    .done(rx_done), .noise(rx_noise), .ferr(rx_ferr), .word(rx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1; rx_s <= 1'b1;
      rate_q <= '0; ctlb_q <= '0; hold_q <= '0; rx_byte <= '0;
      tx9_q <= 1'b0; nine_q <= 1'b0; pen_q <= 1'b0; odd_q <= 1'b0; rx9_q <= 1'b0;
      st_txe <= 1'b1; st_txc <= 1'b1; st_rxf <= 1'b0; st_ovr <= 1'b0;
      st_nf <= 1'b0; st_fe <= 1'b0; st_pe <= 1'b0;
    end else begin
      rx_meta <= rx_i; rx_s <= rx_meta;
      if (reg_wr) begin
        case (reg_addr)
          ADR_RATE: rate_q <= reg_wdata;
          ADR_CTLA: begin
            tx9_q <= reg_wdata[6]; nine_q <= reg_wdata[4];
            pen_q <= reg_wdata[2]; odd_q <= reg_wdata[1];
          end
          ADR_CTLB: ctlb_q <= reg_wdata;
          default: ;
        endcase
      end
      // transmit handoff
      if (tx_end && st_txe) st_txc <= 1'b1;
      if (tx_load) st_txe <= 1'b1;
      if (wr_data) begin
        hold_q <= reg_wdata; st_txe <= 1'b0; st_txc <= 1'b0;
      end
      // receive handoff
      if (rd_clr) begin
        st_rxf <= 1'b0; st_ovr <= 1'b0; st_nf <= 1'b0; st_fe <= 1'b0; st_pe <= 1'b0;
      end
      if (rx_done) begin
        if (st_rxf && !rd_clr) st_ovr <= 1'b1;
        else begin
          rx_byte <= rx_word[7:0]; rx9_q <= rx_word[8]; st_rxf <= 1'b1;
          st_fe <= rx_ferr; st_nf <= rx_noise;
          st_pe <= pen_q && parity_bad(rx_word, nine_q, odd_q);
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_STAT: reg_rdata = {st_txe, st_txc, st_rxf, 1'b0, st_ovr, st_nf, st_fe, st_pe};
      ADR_DATA: reg_rdata = rx_byte;
      ADR_RATE: reg_rdata = rate_q;
      ADR_CTLA: reg_rdata = {rx9_q, tx9_q, 1'b0, nine_q, 1'b0, pen_q, odd_q, 1'b0};
      ADR_CTLB: reg_rdata = ctlb_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_o = (ctlb_q[7] & st_txe) | (ctlb_q[6] & st_txc) | (ctlb_q[5] & (st_rxf | st_ovr));

  p_load_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_data) |=> st_txe);
  p_done_needs_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_txc) |-> st_txe);
  p_overrun_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && st_rxf && !rd_clr) |=> ($stable(rx_byte) && st_ovr));
  p_irq_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlb_q[5] && st_rxf) |-> irq_o);
endmodule

// File: tb/uart_split_baud_test.sv
`timescale 1ns/100ps
module uart_split_baud_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_i = 1'b1;
  logic       tx_o, irq_o;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  uart_split_baud uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_i(rx_i),
    .tx_o(tx_o), .irq_o(irq_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic int pre_f(input int c);
    case (c)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  function automatic int bitc(input int p, input int t);
    return 16 * pre_f(p) * (1 << t);
  endfunction

  function automatic logic [10:0] exp_frame(input logic [8:0] d, input bit nine, input bit pen, input bit odd);
    logic [8:0]  w;
    logic [10:0] f;
    int nb, ones;
    w = d; nb = nine ? 9 : 8; ones = 0; f = '0;
    if (!nine) w[8] = 1'b0;
    if (pen) begin
      for (int i = 0; i < nb - 1; i++) ones += w[i];
      w[nb-1] = (ones % 2 == 1) ^ odd;
    end
    f[0] = 1'b0;
    for (int i = 0; i < nb; i++) f[i+1] = w[i];
    f[nb+1] = 1'b1;
    return f;
  endfunction

  task automatic tx_capture(input int bc, input int nb, output logic [10:0] f);
    int guard = 0;
    f = '0;
    while (tx_o !== 1'b0 && guard < 60000) begin @(negedge clk); guard++; end
    repeat (bc / 2) @(negedge clk);
    f[0] = tx_o;
    for (int i = 1; i <= nb + 1; i++) begin
      repeat (bc) @(negedge clk);
      f[i] = tx_o;
    end
  endtask

  task automatic rx_send(input int bc, input int nb, input logic [10:0] f, input int glitch);
    @(negedge clk);
    for (int i = 0; i <= nb + 1; i++) begin
      rx_i = f[i];
      if (i == glitch) begin
        repeat (8) @(negedge clk); rx_i = ~f[i];
        @(negedge clk); rx_i = f[i];
        repeat (bc - 9) @(negedge clk);
      end else repeat (bc) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  v, d, a2;
    logic [10:0] f, e;
    int hi, lows, guard;
    int pl[4], tl[4];
    void'($urandom(32'd7321));
    pl = '{1, 3, 2, 0}; tl = '{1, 0, 2, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, v);
    check(v == 8'hC0, "R1 status reset", v, 8'hC0);
    check(tx_o == 1'b1 && irq_o == 1'b0, "R1 tx idle/irq", {tx_o, irq_o}, 2'b10);

    // holding register handoff with transmitter disabled
    wr(3'd4, 8'h80);
    @(negedge clk);
    check(irq_o == 1'b1, "R12 empty irq", irq_o, 1);
    wr(3'd1, 8'h5A);
    rd(3'd0, v);
    check(v[7:6] == 2'b00, "R6 flags after write", v[7:6], 0);
    check(irq_o == 1'b0, "R12 irq after write", irq_o, 0);
    wr(3'd4, 8'h0C);
    tx_capture(16, 8, f);
    e = exp_frame(9'h05A, 0, 0, 0);
    check(f == e, "R2 frame 5A", f, e);
    repeat (20) @(negedge clk);
    rd(3'd0, v);
    check(v[7:6] == 2'b11, "R6 flags after frame", v[7:6], 3);

    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      wr(3'd1, d);
      tx_capture(16, 8, f);
      e = exp_frame({1'b0, d}, 0, 0, 0);
      check(f == e, "R2 random frame", f, e);
    end

    // independent rate settings
    for (int k = 0; k < 4; k++) begin
      repeat (40) @(negedge clk);
      wr(3'd2, {2'(pl[k]), 3'(tl[k]), 3'($urandom)});
      d = 8'($urandom);
      wr(3'd1, d);
      tx_capture(bitc(pl[k], tl[k]), 8, f);
      e = exp_frame({1'b0, d}, 0, 0, 0);
      check(f == e, "R3 rate combo", f, e);
    end
    repeat (300) @(negedge clk);
    wr(3'd2, 8'h00);
    repeat (40) @(negedge clk);

    // 9-bit transmit
    for (int k = 0; k < 2; k++) begin
      wr(3'd3, (k == 0) ? 8'h50 : 8'h10);
      d = 8'($urandom);
      wr(3'd1, d);
      tx_capture(16, 9, f);
      e = exp_frame({(k == 0) ? 1'b1 : 1'b0, d}, 1, 0, 0);
      check(f == e, "R4 nine-bit tx", f, e);
    end

    // parity transmit
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ca;
      ca = (k == 0) ? 8'h04 : (k == 1) ? 8'h06 : 8'h14;
      wr(3'd3, ca);
      d = 8'($urandom);
      wr(3'd1, d);
      tx_capture(16, ca[4] ? 9 : 8, f);
      e = exp_frame({1'b0, d}, ca[4], 1, ca[1]);
      check(f == e, "R5 parity tx", f, e);
    end
    wr(3'd3, 8'h00);
    repeat (40) @(negedge clk);

    // receive
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      rx_send(16, 8, exp_frame({1'b0, d}, 0, 0, 0), -1);
      rd(3'd0, v);
      check(v[5] == 1'b1, "R8 rx full", v, 8'h20);
      rd(3'd1, v);
      check(v == d, "R8 rx data", v, d);
      rd(3'd0, v);
      check(v[5] == 1'b0 && v[3:0] == 4'h0, "R8 cleared by read", v, 0);
    end

    wr(3'd2, 8'b00_000_010);
    repeat (40) @(negedge clk);
    d = 8'($urandom);
    rx_send(64, 8, exp_frame({1'b0, d}, 0, 0, 0), -1);
    rd(3'd1, v);
    check(v == d, "R3 rx own divider", v, d);
    wr(3'd2, 8'h00);
    repeat (40) @(negedge clk);

    // noisy bit still decoded
    d = 8'hB6;
    rx_send(16, 8, exp_frame({1'b0, d}, 0, 0, 0), 3);
    rd(3'd0, v);
    check(v[2] == 1'b1, "R7 noise flag", v, 8'h24);
    rd(3'd1, v);
    check(v == d, "R7 majority data", v, d);

    // false start
    @(negedge clk); rx_i = 1'b0;
    repeat (3) @(negedge clk); rx_i = 1'b1;
    repeat (60) @(negedge clk);
    rd(3'd0, v);
    check(v[5] == 1'b0, "R7 false start rejected", v, 0);

    // interrupt from receive
    wr(3'd4, 8'h2C);
    d = 8'($urandom);
    rx_send(16, 8, exp_frame({1'b0, d}, 0, 0, 0), -1);
    check(irq_o == 1'b1, "R12 rx irq set", irq_o, 1);
    rd(3'd1, v);
    @(negedge clk);
    check(irq_o == 1'b0, "R12 rx irq cleared", irq_o, 0);
    wr(3'd4, 8'h0C);

    // overrun
    d = 8'($urandom); a2 = ~d;
    rx_send(16, 8, exp_frame({1'b0, d}, 0, 0, 0), -1);
    rx_send(16, 8, exp_frame({1'b0, a2}, 0, 0, 0), -1);
    rd(3'd0, v);
    check(v[5] == 1'b1 && v[3] == 1'b1, "R9 overrun flag", v, 8'h28);
    rd(3'd1, v);
    check(v == d, "R9 held char kept", v, d);

    // framing error
    d = 8'($urandom);
    f = exp_frame({1'b0, d}, 0, 0, 0);
    f[9] = 1'b0;
    rx_send(16, 8, f, -1);
    repeat (40) @(negedge clk);
    rd(3'd0, v);
    check(v[1] == 1'b1 && v[5] == 1'b1, "R10 framing flag", v, 8'h22);
    rd(3'd1, v);
    check(v == d, "R10 char delivered", v, d);

    // 9-bit receive
    wr(3'd3, 8'h10);
    d = 8'($urandom);
    rx_send(16, 9, exp_frame({1'b1, d}, 1, 0, 0), -1);
    rd(3'd3, v);
    check(v[7] == 1'b1, "R4 ninth bit rx", v, 8'h90);
    rd(3'd1, v);
    check(v == d, "R4 nine-bit low byte", v, d);

    // parity receive
    wr(3'd3, 8'h04);
    d = 8'($urandom);
    f = exp_frame({1'b0, d}, 0, 1, 0);
    rx_send(16, 8, f, -1);
    rd(3'd0, v);
    check(v[0] == 1'b0, "R5 good parity", v[0], 0);
    rd(3'd1, v);
    f[8] = ~f[8];
    rx_send(16, 8, f, -1);
    rd(3'd0, v);
    check(v[0] == 1'b1, "R5 parity error", v[0], 1);
    rd(3'd1, v);
    wr(3'd3, 8'h00);

    // break
    wr(3'd4, 8'h0D);
    repeat (20) @(negedge clk);
    lows = 0;
    for (int k = 0; k < 80; k++) begin
      repeat (5) @(negedge clk);
      lows += (tx_o == 1'b0);
    end
    check(lows == 80, "R11 break held low", lows, 80);
    wr(3'd4, 8'h0C);
    d = 8'($urandom);
    wr(3'd1, d);
    guard = 0;
    while (tx_o !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
    hi = 0;
    while (tx_o === 1'b1 && hi < 1000) begin @(negedge clk); hi++; end
    check(hi >= 16, "R11 mark after break", hi, 16);
    tx_capture(16, 8, f);
    e = exp_frame({1'b0, d}, 0, 0, 0);
    check(f == e, "R11 frame after break", f, e);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule